// File: doc/BRIEF.md
# Machine-Mode Shadow-Stack Region Guard

This block decides whether a memory access that has already been matched against the physical protection regions must take an access fault because of the shadow-stack rules. The region-matching priority encoder sits outside. It delivers the index of the winning region, a flag saying whether any region matched, and that region's read and write permissions. The guard combines these inputs with the effective privilege level, the kind of access and the "checking required" flag. From them it produces either a load access fault or a store/AMO access fault.

At machine level, one protection region can be named as the only region in which shadow-stack instructions may operate. This is done through a small selector field held inside the block. A selector of zero names no region. While the region is named, ordinary writes and implicit accesses that land in it are refused. The selector is written through a write-enable port. The write is refused while the machine-mode lockdown bit is set. Values that do not name an existing region are legalised according to a parameter. The fault outputs are combinational from the access inputs and the stored selector.

Top module: `sspmp_guard`

## Requirements
- R1: After reset, the selector output `sel_o` reads 0.
- R2: With `lockdown_i` at 0, a write strobe `sel_wr_en_i` that carries a value below NUM_REGIONS appears on `sel_o` one clock edge later.
- R3: With `lockdown_i` at 1, a write strobe leaves `sel_o` unchanged.
- R4: A written value of NUM_REGIONS or more is legalised. With CLAMP_ILLEGAL=0 the old value is kept. With CLAMP_ILLEGAL=1 the field becomes NUM_REGIONS-1.
- R5: When the privilege is M (`priv_i`=2'b11) and the selector is 0, push (kind 3) and swap (kind 5) raise `fault_store_o`, and pop-check (kind 4) raises `fault_load_o`.
- R6: When the privilege is M and the selector is nonzero, a push, swap or pop-check raises the fault of its own type unless a region matched (`match_valid_i`=1) and `match_idx_i` equals the selector. An access for which no region matched counts as a miss.
- R7: When the privilege is M and the selector is nonzero, an ordinary store (kind 1) or an implicit write (kind 7) that lands in the selected region raises `fault_store_o`. An ordinary load (kind 0) or fetch (kind 2) that lands there raises no fault.
- R8: When the privilege is M and the selector is nonzero, an implicit read (kind 6) that lands in the selected region raises `fault_load_o`.
- R9: When `chk_req_i` is 1, at any privilege, a push or swap in a region whose `match_w_i` is 0 raises `fault_store_o`, and a pop-check in a region whose `match_r_i` is 0 raises `fault_load_o`.
- R10: Below M (`priv_i` other than 2'b11), the selector rules do not apply. Only R9 can raise a fault.
- R11: `fault_load_o` and `fault_store_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Effective privilege (2'b11 = M) |
| kind_i | input | 3 | Access kind: 0 load, 1 store, 2 fetch, 3 push, 4 pop-check, 5 swap, 6 implicit read, 7 implicit write |
| chk_req_i | input | 1 | Permission checking required |
| match_valid_i | input | 1 | Some region matched |
| match_idx_i | input | SEL_W | Index of the matched region |
| match_r_i | input | 1 | Matched region grants read |
| match_w_i | input | 1 | Matched region grants write |
| lockdown_i | input | 1 | Machine-mode lockdown; freezes the selector |
| sel_wr_en_i | input | 1 | Selector write strobe |
| sel_wr_data_i | input | SEL_W | Selector write value |
| sel_o | output | SEL_W | Current selector value |
| fault_load_o | output | 1 | Load access fault |
| fault_store_o | output | 1 | Store/AMO access fault |

## Verification
The bench builds the guard with NUM_REGIONS=6. SEL_W is then 3, so the two codes 6 and 7 are writable but illegal, which brings the legalisation path of R4 within reach. The main instance keeps CLAMP_ILLEGAL=0. A second instance with CLAMP_ILLEGAL=1 exercises the other generate branch. The highest legal index, 5, is selected so that matches and misses are checked at the edge of the region range.

// File: rtl/sspmp_pkg.sv
package sspmp_pkg;

   typedef enum logic [2:0] {
      ACC_LOAD   = 3'd0,
      ACC_STORE  = 3'd1,
      ACC_FETCH  = 3'd2,
      ACC_PUSH   = 3'd3,
      ACC_POPCHK = 3'd4,
      ACC_SWAP   = 3'd5,
      ACC_IMP_RD = 3'd6,
      ACC_IMP_WR = 3'd7
   } acc_kind_e;

   localparam logic [1:0] PRIV_M = 2'b11;

   typedef struct packed {
      logic ss_st;    // shadow-stack store: push or swap
      logic ss_ld;    // shadow-stack load: pop-check
      logic plain_wr; // ordinary store
      logic imp_rd;   // implicit read
      logic imp_wr;   // implicit write
   } acc_class_t;

endpackage

// File: rtl/sspmp_sel_reg.sv
module sspmp_sel_reg #(
   parameter int NUM_REGIONS   = 16,
   parameter int SEL_W         = 4,
   parameter bit CLAMP_ILLEGAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lockdown_i,
   input  logic             wr_en_i,
   input  logic [SEL_W-1:0] wr_data_i,
   output logic [SEL_W-1:0] sel_q
);
   localparam logic [SEL_W:0]   LIMIT   = (SEL_W + 1)'(NUM_REGIONS);
   localparam logic [SEL_W-1:0] TOP_IDX = SEL_W'(NUM_REGIONS - 1);

   logic             legal;
   logic [SEL_W-1:0] legal_val;

   assign legal = ({1'b0, wr_data_i} < LIMIT);

   generate
      if (CLAMP_ILLEGAL) begin : g_clamp
         assign legal_val = legal ? wr_data_i : TOP_IDX;
      end else begin : g_hold
         assign legal_val = legal ? wr_data_i : sel_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       sel_q <= '0;
      else if (wr_en_i && !lockdown_i)  sel_q <= legal_val;
   end

   p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lockdown_i && wr_en_i) |=> $stable(sel_q));

   p_legal_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, sel_q} < LIMIT));

endmodule

// File: rtl/sspmp_classify.sv
module sspmp_classify
   import sspmp_pkg::*;
(
   input  logic [2:0]  kind_i,
   output acc_class_t  cls_o
);
   acc_kind_e kind;
   assign kind = acc_kind_e'(kind_i);

   always_comb begin
      cls_o          = '0;
      cls_o.ss_st    = (kind == ACC_PUSH) || (kind == ACC_SWAP);
      cls_o.ss_ld    = (kind == ACC_POPCHK);
      cls_o.plain_wr = (kind == ACC_STORE);
      cls_o.imp_rd   = (kind == ACC_IMP_RD);
      cls_o.imp_wr   = (kind == ACC_IMP_WR);
   end
endmodule

// File: rtl/sspmp_rules.sv
module sspmp_rules
   import sspmp_pkg::*;
#(
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             priv_m_i,
   input  acc_class_t       cls_i,
   input  logic             chk_req_i,
   input  logic             match_valid_i,
   input  logic [SEL_W-1:0] match_idx_i,
   input  logic             match_r_i,
   input  logic             match_w_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             fault_load_o,
   output logic             fault_store_o
);
   logic sel_on, hit;
   logic perm_ld, perm_st, mach_ld, mach_st;

   assign sel_on = (sel_i != '0);
   assign hit    = sel_on && match_valid_i && (match_idx_i == sel_i);

   // permission rule, any privilege
   assign perm_ld = chk_req_i && cls_i.ss_ld && !match_r_i;
   assign perm_st = chk_req_i && cls_i.ss_st && !match_w_i;

   // machine-level region rules; a zero selector never hits
   assign mach_ld = (cls_i.ss_ld && !hit) || (cls_i.imp_rd && hit);
   assign mach_st = (cls_i.ss_st && !hit) ||
                    ((cls_i.plain_wr || cls_i.imp_wr) && hit);

   assign fault_load_o  = perm_ld || (priv_m_i && mach_ld);
   assign fault_store_o = perm_st || (priv_m_i && mach_st);

   p_one_type_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fault_load_o, fault_store_o}));

   p_below_m_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!priv_m_i && !chk_req_i) |-> !(fault_load_o || fault_store_o));

   p_sel_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_m_i && !sel_on && cls_i.ss_st) |-> fault_store_o);

   p_hit_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_m_i && hit && cls_i.plain_wr) |-> fault_store_o);

endmodule

// File: rtl/sspmp_guard.sv
module sspmp_guard
   import sspmp_pkg::*;
#(
   parameter int NUM_REGIONS   = 16,
   parameter bit CLAMP_ILLEGAL = 1'b0,
   localparam int SEL_W        = $clog2(NUM_REGIONS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       priv_i,
   input  logic [2:0]       kind_i,
   input  logic             chk_req_i,
   input  logic             match_valid_i,
   input  logic [SEL_W-1:0] match_idx_i,
   input  logic             match_r_i,
   input  logic             match_w_i,
   input  logic             lockdown_i,
   input  logic             sel_wr_en_i,
   input  logic [SEL_W-1:0] sel_wr_data_i,
   output logic [SEL_W-1:0] sel_o,
   output logic             fault_load_o,
   output logic             fault_store_o
);
   generate
      if (NUM_REGIONS < 2 || NUM_REGIONS > 64) begin : g_bad_cfg
         $error("sspmp_guard: NUM_REGIONS must lie in 2..64");
      end
   endgenerate

   acc_class_t cls;

   sspmp_sel_reg #(
      .NUM_REGIONS  (NUM_REGIONS),
      .SEL_W        (SEL_W),
      .CLAMP_ILLEGAL(CLAMP_ILLEGAL)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .lockdown_i(lockdown_i),
      .wr_en_i   (sel_wr_en_i),
      .wr_data_i (sel_wr_data_i),
      .sel_q     (sel_o)
   );

   sspmp_classify u_cls (
      .kind_i(kind_i),
      .cls_o (cls)
   );

   sspmp_rules #(.SEL_W(SEL_W)) u_rules (
      .clk          (clk),
      .rst_n        (rst_n),
      .priv_m_i     (priv_i == PRIV_M),
      .cls_i        (cls),
      .chk_req_i    (chk_req_i),
      .match_valid_i(match_valid_i),
      .match_idx_i  (match_idx_i),
      .match_r_i    (match_r_i),
      .match_w_i    (match_w_i),
      .sel_i        (sel_o),
      .fault_load_o (fault_load_o),
      .fault_store_o(fault_store_o)
   );
endmodule

// File: tb/tb_sspmp_guard.sv
module tb_sspmp_guard;
   localparam int N  = 6;
   localparam int SW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] priv = 2'b11;
   logic [2:0] kind = 3'd0;
   logic chk = 1'b0, mv = 1'b0, mr = 1'b1, mw = 1'b1, lock = 1'b0, wen = 1'b0;
   logic [SW-1:0] idx = '0, wdat = '0;
   logic [SW-1:0] sel, sel_c;
   logic fl, fs, fl_c, fs_c;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sspmp_guard #(.NUM_REGIONS(N), .CLAMP_ILLEGAL(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .priv_i(priv), .kind_i(kind), .chk_req_i(chk),
      .match_valid_i(mv), .match_idx_i(idx), .match_r_i(mr), .match_w_i(mw),
      .lockdown_i(lock), .sel_wr_en_i(wen), .sel_wr_data_i(wdat),
      .sel_o(sel), .fault_load_o(fl), .fault_store_o(fs));

   sspmp_guard #(.NUM_REGIONS(N), .CLAMP_ILLEGAL(1'b1)) dut_clamp (
      .clk(clk), .rst_n(rst_n), .priv_i(priv), .kind_i(kind), .chk_req_i(chk),
      .match_valid_i(mv), .match_idx_i(idx), .match_r_i(mr), .match_w_i(mw),
      .lockdown_i(lock), .sel_wr_en_i(wen), .sel_wr_data_i(wdat),
      .sel_o(sel_c), .fault_load_o(fl_c), .fault_store_o(fs_c));

   task automatic chk_val(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_sel(input logic [SW-1:0] v, input logic lk);
      @(negedge clk); wen = 1'b1; wdat = v; lock = lk;
      @(negedge clk); wen = 1'b0; lock = 1'b0;
   endtask

   // drive an access and check both fault outputs (code: 0 none, 1 load, 2 store)
   task automatic access(input string tag, input logic [1:0] p, input logic [2:0] k,
                         input logic c, input logic v, input logic [SW-1:0] i,
                         input logic r, input logic w, input int exp);
      @(negedge clk);
      priv = p; kind = k; chk = c; mv = v; idx = i; mr = r; mw = w;
      #1;
      chk_val(tag, {30'd0, fs, fl}, exp);
      chk_val({tag, "_R11"}, int'(fl && fs), 0);
   endtask

   task automatic t_reset_r1;
      chk_val("R1 reset sel", sel, 0);
   endtask

   task automatic t_write_r2_r3_r4;
      write_sel(3'd5, 1'b0);
      chk_val("R2 write 5", sel, 5);
      write_sel(3'd2, 1'b1);
      chk_val("R3 locked write", sel, 5);
      write_sel(3'd7, 1'b0);
      chk_val("R4 hold illegal", sel, 5);
      chk_val("R4 clamp illegal", sel_c, 5);
      write_sel(3'd2, 1'b0);
      write_sel(3'd6, 1'b0);
      chk_val("R4 clamp illegal 6", sel_c, 5);
      chk_val("R4 hold illegal 6", sel, 2);
   endtask

   task automatic t_sel_zero_r5;
      write_sel(3'd0, 1'b0);
      access("R5 push sel0", 2'b11, 3'd3, 0, 1, 3'd0, 1, 1, 2);
      access("R5 swap sel0", 2'b11, 3'd5, 0, 1, 3'd0, 1, 1, 2);
      access("R5 pop sel0",  2'b11, 3'd4, 0, 1, 3'd0, 1, 1, 1);
      access("R5 load sel0", 2'b11, 3'd0, 0, 1, 3'd0, 1, 1, 0);
   endtask

   task automatic t_region_r6_r7_r8;
      write_sel(3'd5, 1'b0);
      access("R6 push hit",     2'b11, 3'd3, 0, 1, 3'd5, 1, 1, 0);
      access("R6 pop hit",      2'b11, 3'd4, 0, 1, 3'd5, 1, 1, 0);
      access("R6 push miss",    2'b11, 3'd3, 0, 1, 3'd4, 1, 1, 2);
      access("R6 pop miss",     2'b11, 3'd4, 0, 1, 3'd1, 1, 1, 1);
      access("R6 swap nomatch", 2'b11, 3'd5, 0, 0, 3'd5, 1, 1, 2);
      access("R7 store hit",    2'b11, 3'd1, 0, 1, 3'd5, 1, 1, 2);
      access("R7 impwr hit",    2'b11, 3'd7, 0, 1, 3'd5, 1, 1, 2);
      access("R7 store miss",   2'b11, 3'd1, 0, 1, 3'd3, 1, 1, 0);
      access("R7 load hit",     2'b11, 3'd0, 0, 1, 3'd5, 1, 1, 0);
      access("R7 fetch hit",    2'b11, 3'd2, 0, 1, 3'd5, 1, 1, 0);
      access("R8 imprd hit",    2'b11, 3'd6, 0, 1, 3'd5, 1, 1, 1);
      access("R8 imprd miss",   2'b11, 3'd6, 0, 1, 3'd2, 1, 1, 0);
   endtask

   task automatic t_perm_r9_r10;
      access("R10 S push miss",  2'b01, 3'd3, 0, 1, 3'd2, 1, 1, 0);
      access("R10 U store hit",  2'b00, 3'd1, 0, 1, 3'd5, 1, 1, 0);
      access("R10 S imprd hit",  2'b01, 3'd6, 0, 1, 3'd5, 1, 1, 0);
      access("R9 U push no w",   2'b00, 3'd3, 1, 1, 3'd2, 1, 0, 2);
      access("R9 S pop no r",    2'b01, 3'd4, 1, 1, 3'd2, 0, 1, 1);
      access("R9 S pop r ok",    2'b01, 3'd4, 1, 1, 3'd2, 1, 0, 0);
      access("R9 M swap hit no w", 2'b11, 3'd5, 1, 1, 3'd5, 1, 0, 2);
      access("R9 chk off no w",  2'b00, 3'd5, 0, 1, 3'd2, 0, 0, 0);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_r1();
      t_write_r2_r3_r4();
      t_sel_zero_r5();
      t_region_r6_r7_r8();
      t_perm_r9_r10();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule